// File: doc/BRIEF.md
# RTD Fault Detection Cycle Sequencer

This block holds the configuration register of a resistance-thermometer front end and runs its open/short fault check. A host writes 8-bit configuration words through a single write strobe. Two bits of each word act as a fault-cycle command. The same two bits, read back, report how far the cycle has got. The block drives the enable of the switch in the negative force path. It samples three digital comparator results at fixed points of the cycle and collects them in a sticky 8-bit fault status register. That register is cleared by a command bit of the configuration word.

Two ways of running the check are offered. In the timed mode, the block waits a settling delay before each comparison, once with the switch closed and once with it open. In the two-step host-paced mode, each step performs one comparison at once, and the host waits for the filter to settle between the two writes. A finishing command that arrives without a first step falls back to the timed mode. A word that asks for a conversion and a fault cycle at the same time starts neither.

Top module: `rtd_fault_seq`

## Requirements
- R1: After reset the configuration readback is 0x00 and the fault status is 0x00. The force switch is closed (`fneg_sw_close`=1), `fault_any` is 0 and no cycle is running.
- R2: Bits 7 (bias), 6 (conversion mode), 4 (three-wire) and 0 (notch) hold the last written value. Bit 5 (one-shot) and bit 1 (clear) always read 0.
- R3: A command of 01 in bits 3:2, written while idle, starts the timed cycle. The readback code is 01 for 2×`SETTLE_CYC` cycles. During the first `SETTLE_CYC` cycles the switch is closed, and during the next `SETTLE_CYC` cycles it is open. After that the code returns to 00 and the switch closes.
- R4: The timed cycle takes one sample at the end of its closed phase: `cmp_ref_hi` goes to status bit 5. It takes a second sample at the end of its open phase: `cmp_ref_hi` goes to bit 5, `cmp_ref_lo` to bit 4 and `cmp_rtd_lo` to bit 3.
- R5: A command of 10 written while idle starts manual step 1. For one cycle the switch is closed and the code reads 10. The block then samples `cmp_ref_hi` into bit 5 and opens the switch. The code stays at 10 until the host writes 11.
- R6: A command of 11 written while step 1 waits starts manual step 2. For one cycle the code reads 11 with the switch open. The block then samples all three comparators into bits 5, 4 and 3. After that the switch closes and the code reads 00.
- R7: A command of 11 written while idle, with no step 1 before it, runs the timed cycle exactly as in R3.
- R8: A word with bit 5 set and bit 3 or bit 2 set starts no cycle and no one-shot. Its other stored bits are still written.
- R9: Commands in bits 3:2 are ignored while a cycle runs, and while step 1 waits for any code other than 11. A command of 00 never starts anything.
- R10: A write that starts a cycle leaves bit 6 at 0, whatever value it carries, and stores its bit 7.
- R11: A write with bit 1 set and bits 5, 3 and 2 clear sets all fault status bits to 0. With any of bits 5, 3 or 2 set, that write clears nothing. A sample taken at the same edge as a clear still sets its bit.
- R12: Fault status bits stay set until cleared or reset. Bits 7, 6, 2, 1 and 0 read 0. `fault_any` is the OR of the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe, one word per cycle |
| wr_data | input | 8 | Configuration word to write |
| cmp_ref_hi | input | 1 | Reference-negative level above 85 % of bias |
| cmp_ref_lo | input | 1 | Reference-negative level below 85 % of bias |
| cmp_rtd_lo | input | 1 | Sensor-negative level below 85 % of bias |
| cfg_rdata | output | 8 | Configuration readback with the cycle code in bits 3:2 |
| fault_rdata | output | 8 | Sticky fault status |
| fault_any | output | 1 | OR of all fault status bits |
| fneg_sw_close | output | 1 | 1 closes the negative force switch |

## Verification
On every cycle the assertions check four things. The waiting state of step 1 holds until the 11 command arrives. Step 2 always ends in the idle, switch-closed state. A conflicting one-shot word never starts a cycle, and a cycle start always leaves the conversion-mode bit at 0. They also check that no status bit falls without a clear, and that a clear with no concurrent sample empties the status. The bench scenarios show the rest: the exact length of each timed phase, which comparator is sampled in which phase, the fallback from 11 to the timed cycle, and the way ignored commands mix with stored bits. A cycle-accurate reference model compares every output after every edge under random writes and comparator patterns.

// File: rtl/rtd_fault_pkg.sv
// Shared types and bit positions for the fault detection sequencer.
// Assumes configuration and status words are 8 bits wide.
package rtd_fault_pkg;

    localparam int CFG_W = 8;

    // configuration word bit positions (host-visible encoding)
    localparam int CB_BIAS    = 7;
    localparam int CB_CONV    = 6;
    localparam int CB_ONESHOT = 5;
    localparam int CB_WIRE3   = 4;
    localparam int CB_CMD_HI  = 3;
    localparam int CB_CMD_LO  = 2;
    localparam int CB_CLEAR   = 1;
    localparam int CB_NOTCH   = 0;

    // fault status bit positions
    localparam int FS_REF_HI = 5;
    localparam int FS_REF_LO = 4;
    localparam int FS_RTD_LO = 3;

    // cycle command and progress codes
    localparam logic [1:0] CODE_NONE = 2'b00;
    localparam logic [1:0] CODE_AUTO = 2'b01;
    localparam logic [1:0] CODE_MAN1 = 2'b10;
    localparam logic [1:0] CODE_MAN2 = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AUTO_CLOSED,
        ST_AUTO_OPEN,
        ST_MAN1,
        ST_WAIT,
        ST_MAN2
    } cyc_state_e;

endpackage

// File: rtl/rtd_cfg_reg.sv
// Stores the persistent configuration bits (bias, conversion mode,
// three-wire, notch). Assumes cyc_start_i pulses in the same cycle as
// the write that starts a fault cycle; that write forces conversion mode off.
module rtd_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic bias_i,
    input  logic conv_i,
    input  logic wire3_i,
    input  logic notch_i,
    input  logic cyc_start_i,
    output logic bias_o,
    output logic conv_o,
    output logic wire3_o,
    output logic notch_o
);

    logic bias_q, conv_q, wire3_q, notch_q;

    // capture written bits; a cycle start overrides the conversion mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bias_q  <= 1'b0;
            conv_q  <= 1'b0;
            wire3_q <= 1'b0;
            notch_q <= 1'b0;
        end else if (wr_en_i) begin
            bias_q  <= bias_i;
            conv_q  <= conv_i & ~cyc_start_i;
            wire3_q <= wire3_i;
            notch_q <= notch_i;
        end
    end

    assign bias_o  = bias_q;
    assign conv_o  = conv_q;
    assign wire3_o = wire3_q;
    assign notch_o = notch_q;

    // R10: a cycle start leaves the conversion-mode bit cleared
    assert_start_clears_conv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_i |=> !conv_q);

endmodule

// File: rtl/rtd_cycle_fsm.sv
// Runs the timed and the two-step host-paced fault cycles, drives the
// force switch and produces one-cycle sample pulses for the status
// register. Assumes SETTLE_CYC >= 2 and comparator inputs synchronous to clk.
module rtd_cycle_fsm
    import rtd_fault_pkg::*;
#(
    parameter int SETTLE_CYC = 12500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       cmd_i,
    input  logic             oneshot_i,
    input  logic             cmp_ref_hi_i,
    input  logic             cmp_ref_lo_i,
    input  logic             cmp_rtd_lo_i,
    output logic [1:0]       code_o,
    output logic             sw_close_o,
    output logic             cyc_start_o,
    output logic [CFG_W-1:0] set_o
);

    localparam int CNT_W = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    cyc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cmd_ok;
    logic             last;

    assign cmd_ok      = wr_en_i & ~(oneshot_i & (|cmd_i));
    assign last        = (cnt_q == CNT_LAST);
    assign cyc_start_o = (state_q == ST_IDLE) & cmd_ok & (cmd_i != CODE_NONE);

    // next state, settle counter and comparator sample pulses
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        set_o   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cyc_start_o) begin
                    state_d = (cmd_i == CODE_MAN1) ? ST_MAN1 : ST_AUTO_CLOSED;
                    cnt_d   = '0;
                end
            end
            ST_AUTO_CLOSED: begin
                if (last) begin
                    set_o[FS_REF_HI] = cmp_ref_hi_i;
                    state_d          = ST_AUTO_OPEN;
                    cnt_d            = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_AUTO_OPEN: begin
                if (last) begin
                    set_o[FS_REF_HI] = cmp_ref_hi_i;
                    set_o[FS_REF_LO] = cmp_ref_lo_i;
                    set_o[FS_RTD_LO] = cmp_rtd_lo_i;
                    state_d          = ST_IDLE;
                    cnt_d            = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_MAN1: begin
                set_o[FS_REF_HI] = cmp_ref_hi_i;
                state_d          = ST_WAIT;
            end
            ST_WAIT: begin
                if (cmd_ok && cmd_i == CODE_MAN2) state_d = ST_MAN2;
            end
            ST_MAN2: begin
                set_o[FS_REF_HI] = cmp_ref_hi_i;
                set_o[FS_REF_LO] = cmp_ref_lo_i;
                set_o[FS_RTD_LO] = cmp_rtd_lo_i;
                state_d          = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // progress code and switch enable decoded from the state
    always_comb begin
        unique case (state_q)
            ST_AUTO_CLOSED, ST_AUTO_OPEN: code_o = CODE_AUTO;
            ST_MAN1, ST_WAIT:             code_o = CODE_MAN1;
            ST_MAN2:                      code_o = CODE_MAN2;
            default:                      code_o = CODE_NONE;
        endcase
        sw_close_o = !(state_q == ST_AUTO_OPEN || state_q == ST_WAIT || state_q == ST_MAN2);
    end

    // R5: the open, waiting step 1 holds until a valid 11 command
    assert_wait_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == CODE_MAN1 && !sw_close_o &&
         !(wr_en_i && !oneshot_i && cmd_i == CODE_MAN2))
        |=> (code_o == CODE_MAN1 && !sw_close_o));

    // R6: step 2 lasts one cycle and ends idle with the switch closed
    assert_man2_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == CODE_MAN2) |=> (code_o == CODE_NONE && sw_close_o));

    // R8: a one-shot combined with a cycle command starts nothing
    assert_conflict_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == CODE_NONE && wr_en_i && oneshot_i && (|cmd_i))
        |=> (code_o == CODE_NONE));

    // R3: settle counter never passes its limit
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

endmodule

// File: rtl/rtd_fault_stat.sv
// Sticky fault status register. Sample pulses set bits; a clear request
// empties it, with a same-edge sample still winning. Assumes set_i only
// carries bits the sequencer can raise.
module rtd_fault_stat
    import rtd_fault_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] set_i,
    input  logic             clr_i,
    output logic [CFG_W-1:0] stat_o
);

    logic [CFG_W-1:0] stat_q;

    // accumulate samples; clear first, then merge new samples
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (clr_i ? '0 : stat_q) | set_i;
    end

    assign stat_o = stat_q;

    // R12: no bit falls without a clear
    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R11: a clear with no concurrent sample empties the register
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (stat_q == '0));

endmodule

// File: rtl/rtd_fault_seq.sv
// Top of the fault detection sequencer: decodes configuration writes,
// joins the stored bits with the live cycle code for readback and
// exposes the sticky status. Assumes one write per cycle.
module rtd_fault_seq
    import rtd_fault_pkg::*;
#(
    parameter int SETTLE_CYC = 12500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             cmp_ref_hi,
    input  logic             cmp_ref_lo,
    input  logic             cmp_rtd_lo,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [CFG_W-1:0] fault_rdata,
    output logic             fault_any,
    output logic             fneg_sw_close
);

    logic [1:0]       code;
    logic             cyc_start;
    logic [CFG_W-1:0] set_bits;
    logic             bias, conv, wire3, notch;
    logic             clr_req;

    assign clr_req = wr_en & wr_data[CB_CLEAR] & ~wr_data[CB_ONESHOT]
                   & ~wr_data[CB_CMD_HI] & ~wr_data[CB_CMD_LO];

    rtd_cycle_fsm #(.SETTLE_CYC(SETTLE_CYC)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .cmd_i        (wr_data[CB_CMD_HI:CB_CMD_LO]),
        .oneshot_i    (wr_data[CB_ONESHOT]),
        .cmp_ref_hi_i (cmp_ref_hi),
        .cmp_ref_lo_i (cmp_ref_lo),
        .cmp_rtd_lo_i (cmp_rtd_lo),
        .code_o       (code),
        .sw_close_o   (fneg_sw_close),
        .cyc_start_o  (cyc_start),
        .set_o        (set_bits)
    );

    rtd_cfg_reg cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .bias_i      (wr_data[CB_BIAS]),
        .conv_i      (wr_data[CB_CONV]),
        .wire3_i     (wr_data[CB_WIRE3]),
        .notch_i     (wr_data[CB_NOTCH]),
        .cyc_start_i (cyc_start),
        .bias_o      (bias),
        .conv_o      (conv),
        .wire3_o     (wire3),
        .notch_o     (notch)
    );

    rtd_fault_stat stat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_bits),
        .clr_i  (clr_req),
        .stat_o (fault_rdata)
    );

    // readback: stored bits, self-clearing bits as 0, live cycle code
    always_comb begin
        cfg_rdata                        = '0;
        cfg_rdata[CB_BIAS]               = bias;
        cfg_rdata[CB_CONV]               = conv;
        cfg_rdata[CB_WIRE3]              = wire3;
        cfg_rdata[CB_CMD_HI:CB_CMD_LO]   = code;
        cfg_rdata[CB_NOTCH]              = notch;
    end

    assign fault_any = |fault_rdata;

endmodule

// File: tb/rtd_fault_seq_tb.sv
module rtd_fault_seq_tb_top;

    localparam int S = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       rh, rl, rt;
    logic [7:0] cfg_rdata, fault_rdata;
    logic       fault_any, fneg_sw_close;

    int checks = 0;
    int fails  = 0;

    // reference model state: 0 idle,1 timed closed,2 timed open,3 step1,4 wait,5 step2
    int         m_st;
    int         m_cnt;
    logic [7:0] m_keep;
    logic [7:0] m_stat;

    always #4 clk = ~clk;

    rtd_fault_seq #(.SETTLE_CYC(S)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .cmp_ref_hi    (rh),
        .cmp_ref_lo    (rl),
        .cmp_rtd_lo    (rt),
        .cfg_rdata     (cfg_rdata),
        .fault_rdata   (fault_rdata),
        .fault_any     (fault_any),
        .fneg_sw_close (fneg_sw_close)
    );

    function automatic logic [7:0] exp_cfg();
        logic [1:0] c;
        case (m_st)
            1, 2:    c = 2'b01;
            3, 4:    c = 2'b10;
            5:       c = 2'b11;
            default: c = 2'b00;
        endcase
        return m_keep | {4'b0000, c, 2'b00};
    endfunction

    function automatic logic exp_sw();
        return !(m_st == 2 || m_st == 4 || m_st == 5);
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // advance the model by one edge using the inputs applied before it
    task automatic model_edge();
        logic [7:0] set;
        int         st, cnt;
        logic [1:0] cmd;
        logic       ok;
        set = 8'h00;
        st  = m_st;
        cnt = m_cnt;
        case (m_st)
            1: if (m_cnt == S - 1) begin set[5] = rh; st = 2; cnt = 0; end else cnt = m_cnt + 1;
            2: if (m_cnt == S - 1) begin set[5] = rh; set[4] = rl; set[3] = rt; st = 0; cnt = 0; end
               else cnt = m_cnt + 1;
            3: begin set[5] = rh; st = 4; end
            5: begin set[5] = rh; set[4] = rl; set[3] = rt; st = 0; end
            default: ;
        endcase
        if (wr_en) begin
            cmd = wr_data[3:2];
            ok  = !(wr_data[5] && cmd != 2'b00);
            m_keep = wr_data & 8'hD1;
            if (ok && m_st == 0 && cmd != 2'b00) begin
                st = (cmd == 2'b10) ? 3 : 1;
                cnt = 0;
                m_keep[6] = 1'b0;
            end
            if (ok && m_st == 4 && cmd == 2'b11) st = 5;
            if (wr_data[1] && !wr_data[5] && !wr_data[3] && !wr_data[2]) m_stat = 8'h00;
        end
        m_stat = m_stat | set;
        m_st   = st;
        m_cnt  = cnt;
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic a, input logic b, input logic c);
        wr_en   = w;
        wr_data = d;
        rh = a; rl = b; rt = c;
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        chk("R2", "cfg model", cfg_rdata, exp_cfg());
        chk("R12", "status model", fault_rdata, m_stat);
        chk("R3", "switch model", {7'd0, fneg_sw_close}, {7'd0, exp_sw()});
        chk("R12", "flag model", {7'd0, fault_any}, {7'd0, |m_stat});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; rh = 0; rl = 0; rt = 0;
        m_st = 0; m_cnt = 0; m_keep = 8'h00; m_stat = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "cfg reset", cfg_rdata, 8'h00);
        chk("R1", "status reset", fault_rdata, 8'h00);
        chk("R1", "switch reset", {7'd0, fneg_sw_close}, 8'h01);
        chk("R1", "flag reset", {7'd0, fault_any}, 8'h00);

        // R2 stored bits, one-shot and clear read 0
        step(1, 8'hF3, 0, 0, 0);
        chk("R2", "stored bits", cfg_rdata, 8'hD1);

        // R3/R10 timed cycle, conversion bit forced off
        step(1, 8'hC4, 0, 1, 1);
        chk("R10", "start forces mode", cfg_rdata, 8'h84);
        chk("R3", "closed at start", {7'd0, fneg_sw_close}, 8'h01);
        repeat (S - 1) step(0, 8'h00, 0, 1, 1);
        chk("R3", "closed end", {7'd0, fneg_sw_close}, 8'h01);
        step(0, 8'h00, 0, 1, 1);
        chk("R3", "open phase", {7'd0, fneg_sw_close}, 8'h00);
        chk("R4", "closed phase ignores low cmps", fault_rdata, 8'h00);
        repeat (S - 1) step(0, 8'h00, 0, 1, 1);
        chk("R3", "still running", cfg_rdata, 8'h84);
        step(0, 8'h00, 0, 1, 1);
        chk("R3", "done code", cfg_rdata, 8'h80);
        chk("R3", "closed after", {7'd0, fneg_sw_close}, 8'h01);
        chk("R4", "open phase sample", fault_rdata, 8'h18);
        chk("R12", "flag set", {7'd0, fault_any}, 8'h01);
        step(0, 8'h00, 0, 0, 0);
        chk("R12", "sticky", fault_rdata, 8'h18);

        // R11 clear blocked, then clear
        step(1, 8'h22, 0, 0, 0);
        chk("R11", "blocked clear", fault_rdata, 8'h18);
        step(1, 8'h02, 0, 0, 0);
        chk("R11", "clear", fault_rdata, 8'h00);

        // R5 manual step 1
        step(1, 8'h88, 0, 0, 0);
        chk("R5", "step1 code", cfg_rdata, 8'h88);
        chk("R5", "step1 closed", {7'd0, fneg_sw_close}, 8'h01);
        step(0, 8'h00, 1, 0, 0);
        chk("R5", "step1 sample", fault_rdata, 8'h20);
        chk("R5", "wait open", {7'd0, fneg_sw_close}, 8'h00);
        repeat (4) step(0, 8'h00, 0, 1, 1);
        chk("R5", "wait holds", cfg_rdata, 8'h88);
        chk("R5", "wait holds no sample", fault_rdata, 8'h20);

        // R9 other codes while waiting
        step(1, 8'h84, 0, 0, 0);
        chk("R9", "01 in wait", cfg_rdata, 8'h88);
        step(1, 8'h80, 0, 0, 0);
        chk("R9", "00 in wait", cfg_rdata, 8'h88);

        // R6 step 2
        step(1, 8'h8C, 0, 0, 0);
        chk("R6", "step2 code", cfg_rdata, 8'h8C);
        chk("R6", "step2 open", {7'd0, fneg_sw_close}, 8'h00);
        step(0, 8'h00, 0, 1, 0);
        chk("R6", "step2 done", cfg_rdata, 8'h80);
        chk("R6", "step2 closes", {7'd0, fneg_sw_close}, 8'h01);
        chk("R6", "step2 sample", fault_rdata, 8'h30);

        // R8 conflicting one-shot and command
        step(1, 8'h25, 0, 0, 0);
        chk("R8", "conflict ignored", cfg_rdata, 8'h01);
        step(0, 8'h00, 0, 0, 0);
        chk("R8", "still idle", cfg_rdata, 8'h01);

        // R7 fallback, R9 ignored command while running
        step(1, 8'h0C, 0, 0, 0);
        chk("R7", "fallback timed", cfg_rdata, 8'h04);
        step(1, 8'h08, 0, 0, 0);
        chk("R9", "ignored while running", cfg_rdata, 8'h04);
        chk("R7", "fallback closed", {7'd0, fneg_sw_close}, 8'h01);
        repeat (2 * S - 1) step(0, 8'h00, 0, 0, 0);
        chk("R7", "fallback done", cfg_rdata, 8'h00);

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            logic       w;
            logic [7:0] d;
            w = ($urandom % 5) == 0;
            d = 8'($urandom);
            step(w, d, ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule